// File: doc/BRIEF.md
# Transaction-Granting Stream Sink

This block terminates a three-channel streaming transfer interface on the receive side. A source announces each transaction with a 64-bit request beat. The request carries a byte count, a channel number, start-of-frame and end-of-frame flags and, on the opening transaction of a frame, the total frame length. The sink compares the requested count with the free room in its local beat buffer. It answers with a 64-bit response that echoes the request with the count replaced by a grant. It then takes exactly the granted number of bytes from a 512-bit data stream and stores them. A grant of zero means the source must try again later, and no data follows.

Each stored beat keeps its valid byte count. Bytes past the granted length in the final beat are zeroed before storage. A simple valid/ready drain port removes stored beats in arrival order. For each of a small set of tracked channels, the sink follows frame boundaries and the running byte total. It raises a one-cycle error pulse when the frame flags, the frame length or the data framing are inconsistent.

Top module: `stream_grant_sink`

## Requirements
- R1: After a synchronous active-high reset: req_tready is 1, resp_tvalid, data_tready, drain_valid and proto_err are 0, frame_open is all zero, and free_bytes equals BUF_BEATS*64.
- R2: A request is taken only while no transaction is in progress. resp_tvalid rises in the cycle after the request handshake and stays high, with resp_tdata unchanged, until resp_tready is seen.
- R3: Descriptor layout for request and response: bits 31:0 frame length, 40:32 channel, 41 start-of-frame, 42 end-of-frame, 43 bypass flag, 47:44 spare, 63:48 byte count. The response copies bits 47:0 of the request. Its byte count is min(requested count, free_bytes) at the request handshake.
- R4: After a zero grant is handshaken, data_tready stays low and req_tready returns to 1 in the next cycle.
- R5: After a nonzero grant G is handshaken, data_tready is high for exactly ceil(G/64) accepted data beats and then drops.
- R6: Each accepted beat is stored with a valid byte count: 64 for every beat but the last, and G mod 64 for the last beat (64 when that is 0). Bytes at and above that count (byte k in bits 8k+7:8k) are stored as zero.
- R7: free_bytes equals 64 times the number of unused beat slots. A partially filled beat uses a whole slot.
- R8: A data beat whose data_tlast differs from "this is the final granted beat" makes proto_err high for one cycle, in the cycle after that beat.
- R9: Channel c is tracked in slot c mod NUM_CH. frame_open for that slot sets on the handshake of a nonzero grant carrying start-of-frame. It clears on the handshake of a grant carrying end-of-frame that equals the full requested count.
- R10: On the handshake of a nonzero grant, proto_err pulses in the next cycle if any of these holds: start-of-frame arrives on an open slot; a transaction without start-of-frame arrives on a closed slot; the slot's running total exceeds its frame length; or a closing transaction ends with a total different from the frame length.
- R11: drain_valid is high while a stored beat is available. drain_data and drain_nbytes hold steady until drain_ready, and beats leave in arrival order, one per drain_valid and drain_ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_tvalid | input | 1 | Request beat valid |
| req_tready | output | 1 | Request beat ready |
| req_tdata | input | 64 | Request descriptor |
| resp_tvalid | output | 1 | Response beat valid |
| resp_tready | input | 1 | Response beat ready |
| resp_tdata | output | 64 | Response descriptor with grant |
| data_tvalid | input | 1 | Data beat valid |
| data_tready | output | 1 | Data beat ready |
| data_tdata | input | 512 | Data beat, byte 0 at the LSB |
| data_tlast | input | 1 | Final beat of the transaction |
| drain_valid | output | 1 | Stored beat available |
| drain_ready | input | 1 | Drain side takes the beat |
| drain_data | output | 512 | Stored beat, unused bytes zero |
| drain_nbytes | output | 7 | Valid bytes in drain_data (1 to 64) |
| free_bytes | output | clog2(BUF_BEATS*64+1) | Free room in bytes |
| frame_open | output | NUM_CH | Per-slot frame-in-progress flags |
| proto_err | output | 1 | One-cycle protocol error pulse |

## Verification
The assertions assume the source follows the handshake rules. It holds req_tvalid and the descriptor until req_tready. It never drives data_tvalid outside a granted data phase, and it never sends more beats than granted. The checks also assume the request byte count is at least 1. The stimulus drives every valid signal from tasks that wait for ready at the falling edge, so no beat is dropped or doubled. The tasks send exactly ceil(grant/64) beats per transaction, and only vary data_tlast to provoke framing errors. Flag and length errors are provoked only through well-formed handshakes, so every error pulse comes from the intended frame condition.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  localparam int DESC_W     = 64;
  localparam int BLEN_W     = 16;
  localparam int BEAT_BYTES = 64;
  localparam int BEAT_OFS_W = $clog2(BEAT_BYTES);
  localparam int NB_W       = BEAT_OFS_W + 1;

  typedef struct packed {
    logic [BLEN_W-1:0] blen;    // 63:48 byte count
    logic [3:0]        spare;   // 47:44
    logic              bypass;  // 43
    logic              eof;     // 42
    logic              sof;     // 41
    logic [8:0]        chan;    // 40:32
    logic [31:0]       flen;    // 31:0 frame length
  } xfer_desc_t;
endpackage

// File: rtl/sgs_xfer_ctrl.sv
module sgs_xfer_ctrl
  import sgs_pkg::*;
#(
  parameter int FREE_W = 11,
  parameter int DATA_W = 512,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_tvalid,
  output logic              req_tready,
  input  logic [DESC_W-1:0] req_tdata,
  output logic              resp_tvalid,
  input  logic              resp_tready,
  output logic [DESC_W-1:0] resp_tdata,
  input  logic              data_tvalid,
  output logic              data_tready,
  input  logic [DATA_W-1:0] data_tdata,
  input  logic              data_tlast,
  input  logic [FREE_W-1:0] free_bytes,
  output logic              wr_en,
  output logic [NB_W-1:0]   wr_nbytes,
  output logic [DATA_W-1:0] wr_data,
  output logic              grant_fire,
  output logic [BLEN_W-1:0] grant_bytes,
  output logic              grant_full,
  output logic              grant_sof,
  output logic              grant_eof,
  output logic [31:0]       grant_flen,
  output logic [IDX_W-1:0]  grant_idx,
  output logic              tlast_err
);
  localparam int CNT_W = BLEN_W - BEAT_OFS_W + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RESP, ST_DATA} st_t;

  st_t               st;
  xfer_desc_t        req_d, resp_n;
  logic [BLEN_W-1:0] grant_n, grant_q, blen_q;
  logic [CNT_W-1:0]  beats_left;
  logic [NB_W-1:0]   tail_nb;
  logic              sof_q, eof_q;
  logic [31:0]       flen_q;
  logic [IDX_W-1:0]  idx_q;
  logic              last_beat;
  logic [DATA_W-1:0] keep_mask;

  assign req_d = xfer_desc_t'(req_tdata);

  always_comb begin
    if (32'(req_d.blen) < 32'(free_bytes)) grant_n = req_d.blen;
    else                                   grant_n = BLEN_W'(free_bytes);
    resp_n      = req_d;
    resp_n.blen = grant_n;
  end

  assign req_tready  = (st == ST_IDLE);
  assign resp_tvalid = (st == ST_RESP);
  assign data_tready = (st == ST_DATA);
  assign last_beat   = (beats_left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      resp_tdata <= '0;
      grant_q    <= '0;
      blen_q     <= '0;
      beats_left <= '0;
      tail_nb    <= '0;
      sof_q      <= 1'b0;
      eof_q      <= 1'b0;
      flen_q     <= '0;
      idx_q      <= '0;
      tlast_err  <= 1'b0;
    end else begin
      tlast_err <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_tvalid) begin
          resp_tdata <= DESC_W'(resp_n);
          grant_q    <= grant_n;
          blen_q     <= req_d.blen;
          sof_q      <= req_d.sof;
          eof_q      <= req_d.eof;
          flen_q     <= req_d.flen;
          idx_q      <= req_d.chan[IDX_W-1:0];
          st         <= ST_RESP;
        end
        ST_RESP: if (resp_tready) begin
          beats_left <= CNT_W'((32'(grant_q) + BEAT_BYTES - 1) / BEAT_BYTES);
          tail_nb    <= (grant_q[BEAT_OFS_W-1:0] == '0) ? NB_W'(BEAT_BYTES)
                                                        : NB_W'(grant_q[BEAT_OFS_W-1:0]);
          st         <= (grant_q == '0) ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (data_tvalid) begin
          beats_left <= beats_left - CNT_W'(1);
          tlast_err  <= (data_tlast != last_beat);
          if (last_beat) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign wr_en     = (st == ST_DATA) && data_tvalid;
  assign wr_nbytes = last_beat ? tail_nb : NB_W'(BEAT_BYTES);
  always_comb keep_mask = {DATA_W{1'b1}} >> ((BEAT_BYTES - int'(wr_nbytes)) * 8);
  assign wr_data   = data_tdata & keep_mask;

  assign grant_fire  = (st == ST_RESP) && resp_tready && (grant_q != '0);
  assign grant_bytes = grant_q;
  assign grant_full  = (grant_q == blen_q);
  assign grant_sof   = sof_q;
  assign grant_eof   = eof_q;
  assign grant_flen  = flen_q;
  assign grant_idx   = idx_q;

  p_resp_hold_r2: assert property (@(posedge clk) disable iff (rst)
    resp_tvalid && !resp_tready |=> resp_tvalid && $stable(resp_tdata));
  p_grant_le_r3: assert property (@(posedge clk) disable iff (rst)
    resp_tvalid |-> resp_tdata[63:48] <= blen_q);
  p_zero_grant_r4: assert property (@(posedge clk) disable iff (rst)
    resp_tvalid && resp_tready && (resp_tdata[63:48] == '0) |=> req_tready && !data_tready);
  p_data_after_resp_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(data_tready) |-> $past(resp_tvalid && resp_tready));
endmodule

// File: rtl/sgs_frame_track.sv
module sgs_frame_track
  import sgs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [BLEN_W-1:0] grant,
  input  logic              full,
  input  logic              sof,
  input  logic              eof,
  input  logic [31:0]       flen,
  input  logic [IDX_W-1:0]  idx,
  output logic [NUM_CH-1:0] open_q,
  output logic              err_q
);
  logic [31:0] got_q [NUM_CH];
  logic [31:0] exp_q [NUM_CH];
  logic [31:0] base, lim;
  logic [32:0] sum;
  logic        closes, skip, bad;

  always_comb begin
    base   = sof ? 32'd0 : got_q[idx];
    lim    = sof ? flen  : exp_q[idx];
    sum    = {1'b0, base} + 33'(grant);
    closes = eof && full;
    skip   = !sof && !open_q[idx];
    bad    = skip || (sof && open_q[idx]) || (sum > {1'b0, lim})
             || (closes && (sum != {1'b0, lim}));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= '0;
      err_q  <= 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        got_q[c] <= '0;
        exp_q[c] <= '0;
      end
    end else begin
      err_q <= fire && bad;
      for (int c = 0; c < NUM_CH; c++) begin
        if (fire && !skip && (idx == IDX_W'(c))) begin
          open_q[c] <= !closes;
          got_q[c]  <= sum[31:0];
          if (sof) exp_q[c] <= flen;
        end
      end
    end
  end

  p_open_only_on_grant_r9: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(open_q));
  p_err_needs_event_r10: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !err_q);
endmodule

// File: rtl/sgs_beat_fifo.sv
module sgs_beat_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 519
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [W-1:0]             wr_data,
  input  logic                     rd_ready,
  output logic                     rd_valid,
  output logic [W-1:0]             rd_data,
  output logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] mem_cnt;
  logic          load, pop;

  assign pop  = rd_valid && rd_ready;
  assign load = (!rd_valid || rd_ready) && (mem_cnt != '0);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
    if (load)  rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      mem_cnt  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (load)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      mem_cnt <= mem_cnt + CW'(wr_en) - CW'(load);
      if (load)     rd_valid <= 1'b1;
      else if (pop) rd_valid <= 1'b0;
    end
  end

  assign occ = mem_cnt + CW'(rd_valid);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> occ < CW'(DEPTH));
  p_drain_hold_r11: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
endmodule

// File: rtl/stream_grant_sink.sv
module stream_grant_sink
  import sgs_pkg::*;
#(
  parameter int BUF_BEATS = 16,
  parameter int NUM_CH    = 4,
  parameter int DATA_W    = 512
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_tvalid,
  output logic                                   req_tready,
  input  logic [63:0]                            req_tdata,
  output logic                                   resp_tvalid,
  input  logic                                   resp_tready,
  output logic [63:0]                            resp_tdata,
  input  logic                                   data_tvalid,
  output logic                                   data_tready,
  input  logic [DATA_W-1:0]                      data_tdata,
  input  logic                                   data_tlast,
  output logic                                   drain_valid,
  input  logic                                   drain_ready,
  output logic [DATA_W-1:0]                      drain_data,
  output logic [6:0]                             drain_nbytes,
  output logic [$clog2(BUF_BEATS*64+1)-1:0]      free_bytes,
  output logic [NUM_CH-1:0]                      frame_open,
  output logic                                   proto_err
);
  localparam int FREE_W = $clog2(BUF_BEATS*BEAT_BYTES+1);
  localparam int IDX_W  = $clog2(NUM_CH);
  localparam int OCC_W  = $clog2(BUF_BEATS+1);
  localparam int ENT_W  = NB_W + DATA_W;

  logic              wr_en, grant_fire, grant_full, grant_sof, grant_eof;
  logic              tlast_err, frame_err;
  logic [NB_W-1:0]   wr_nbytes;
  logic [DATA_W-1:0] wr_data;
  logic [BLEN_W-1:0] grant_bytes;
  logic [31:0]       grant_flen;
  logic [IDX_W-1:0]  grant_idx;
  logic [ENT_W-1:0]  head;
  logic [OCC_W-1:0]  occ;

  sgs_xfer_ctrl #(.FREE_W(FREE_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk, .rst,
    .req_tvalid, .req_tready, .req_tdata,
    .resp_tvalid, .resp_tready, .resp_tdata,
    .data_tvalid, .data_tready, .data_tdata, .data_tlast,
    .free_bytes,
    .wr_en, .wr_nbytes, .wr_data,
    .grant_fire, .grant_bytes, .grant_full, .grant_sof, .grant_eof,
    .grant_flen, .grant_idx, .tlast_err
  );

  sgs_frame_track #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_track (
    .clk, .rst,
    .fire(grant_fire), .grant(grant_bytes), .full(grant_full),
    .sof(grant_sof), .eof(grant_eof), .flen(grant_flen), .idx(grant_idx),
    .open_q(frame_open), .err_q(frame_err)
  );

  sgs_beat_fifo #(.DEPTH(BUF_BEATS), .W(ENT_W)) u_buf (
    .clk, .rst,
    .wr_en, .wr_data({wr_nbytes, wr_data}),
    .rd_ready(drain_ready), .rd_valid(drain_valid), .rd_data(head), .occ
  );

  assign drain_data   = head[DATA_W-1:0];
  assign drain_nbytes = head[ENT_W-1 -: NB_W];
  assign free_bytes   = FREE_W'((BUF_BEATS - int'(occ)) * BEAT_BYTES);
  assign proto_err    = tlast_err | frame_err;
endmodule

// File: tb/tb_stream_grant_sink.sv
`timescale 1ns/1ps
module tb_stream_grant_sink;
  localparam int BUF_BEATS = 16;
  localparam int NUM_CH    = 4;
  localparam int CAP       = BUF_BEATS * 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_tvalid = 1'b0, req_tready;
  logic [63:0] req_tdata = '0;
  logic resp_tvalid, resp_tready = 1'b0;
  logic [63:0] resp_tdata;
  logic data_tvalid = 1'b0, data_tready, data_tlast = 1'b0;
  logic [511:0] data_tdata = '0;
  logic drain_valid, drain_ready;
  logic [511:0] drain_data;
  logic [6:0] drain_nbytes;
  logic [10:0] free_bytes;
  logic [NUM_CH-1:0] frame_open;
  logic proto_err;

  stream_grant_sink #(.BUF_BEATS(BUF_BEATS), .NUM_CH(NUM_CH)) dut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, drain_mode = 0;
  bit cmp_on = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    drain_ready <= (drain_mode == 1) || (drain_mode == 2 && (lfsr[0] | lfsr[5]));
  end

  // ---------------- behavioural reference ----------------
  int m_st, m_g, m_bl, m_blen, m_idx;
  bit m_sof, m_eof, m_err, m_ov;
  longint m_flen;
  logic [63:0] m_resp;
  logic [518:0] m_out;
  logic [518:0] q_mem[$];
  bit f_open[NUM_CH];
  longint f_exp[NUM_CH], f_got[NUM_CH];

  always @(posedge clk) begin
    int free_pre, nb, tail;
    bit tl, fe, do_push, ld, pp, skip, closes;
    longint base, lim, sum;
    logic [518:0] item;
    if (rst) begin
      m_st = 0; m_g = 0; m_bl = 0; m_resp = '0; m_err = 0; m_ov = 0;
      q_mem.delete();
      for (int c = 0; c < NUM_CH; c++) begin f_open[c] = 0; f_exp[c] = 0; f_got[c] = 0; end
    end else begin
      free_pre = (BUF_BEATS - (q_mem.size() + (m_ov ? 1 : 0))) * 64;
      tl = 0; fe = 0; do_push = 0; item = '0;
      case (m_st)
        0: if (req_tvalid) begin
          m_blen = int'(req_tdata[63:48]);
          m_g    = (m_blen < free_pre) ? m_blen : free_pre;
          m_resp = {16'(m_g), req_tdata[47:0]};
          m_sof  = req_tdata[41]; m_eof = req_tdata[42];
          m_flen = longint'(req_tdata[31:0]); m_idx = int'(req_tdata[32 +: 2]);
          m_st   = 1;
        end
        1: if (resp_tready) begin
          if (m_g == 0) m_st = 0;
          else begin
            m_st = 2; m_bl = (m_g + 63) / 64;
            skip = !m_sof && !f_open[m_idx];
            base = m_sof ? 0 : f_got[m_idx];
            lim  = m_sof ? m_flen : f_exp[m_idx];
            sum  = base + m_g;
            closes = m_eof && (m_g == m_blen);
            fe = skip || (m_sof && f_open[m_idx]) || (sum > lim) || (closes && sum != lim);
            if (!skip) begin
              f_open[m_idx] = !closes; f_got[m_idx] = sum;
              if (m_sof) f_exp[m_idx] = m_flen;
            end
          end
        end
        default: if (data_tvalid) begin
          tail = (m_g % 64 == 0) ? 64 : m_g % 64;
          nb = (m_bl == 1) ? tail : 64;
          item[518:512] = 7'(nb);
          for (int b = 0; b < 64; b++) if (b < nb) item[b*8 +: 8] = data_tdata[b*8 +: 8];
          do_push = 1;
          tl = (data_tlast != (m_bl == 1));
          m_bl--;
          if (m_bl == 0) m_st = 0;
        end
      endcase
      pp = m_ov && drain_ready;
      ld = (!m_ov || drain_ready) && q_mem.size() > 0;
      if (ld) begin m_out = q_mem.pop_front(); m_ov = 1; end
      else if (pp) m_ov = 0;
      if (do_push) q_mem.push_back(item);
      m_err = tl | fe;
    end
  end

  logic [NUM_CH-1:0] m_open_vec;
  always_comb for (int c = 0; c < NUM_CH; c++) m_open_vec[c] = f_open[c];

  always @(negedge clk) if (cmp_on) begin
    chk(req_tready === (m_st == 0), "R2", "req_tready", 512'(req_tready), 512'(m_st == 0));
    chk(resp_tvalid === (m_st == 1), "R2", "resp_tvalid", 512'(resp_tvalid), 512'(m_st == 1));
    chk(resp_tdata === m_resp, "R3", "resp_tdata", 512'(resp_tdata), 512'(m_resp));
    chk(data_tready === (m_st == 2), "R5", "data_tready", 512'(data_tready), 512'(m_st == 2));
    chk(int'(free_bytes) == (BUF_BEATS - q_mem.size() - (m_ov ? 1 : 0)) * 64, "R7", "free_bytes",
        512'(free_bytes), 512'((BUF_BEATS - q_mem.size() - (m_ov ? 1 : 0)) * 64));
    chk(drain_valid === m_ov, "R11", "drain_valid", 512'(drain_valid), 512'(m_ov));
    if (m_ov) begin
      chk(drain_data === m_out[511:0], "R6", "drain_data", drain_data, m_out[511:0]);
      chk(drain_nbytes === m_out[518:512], "R6", "drain_nbytes", 512'(drain_nbytes), 512'(m_out[518:512]));
    end
    chk(frame_open === m_open_vec, "R9", "frame_open", 512'(frame_open), 512'(m_open_vec));
    chk(proto_err === m_err, "R8 R10", "proto_err", 512'(proto_err), 512'(m_err));
  end

  // ---------------- stimulus ----------------
  function automatic logic [63:0] mk(int chan, bit sof, bit eof, int flen, int blen, logic [4:0] extra);
    return {16'(blen), extra[3:0], extra[4], eof, sof, 9'(chan), 32'(flen)};
  endfunction

  int seed = 1;
  task automatic xact(input int chan, input bit sof, input bit eof, input int flen,
                      input int blen, input int exp_g, input int tlmode, input int exp_ferr,
                      input logic [4:0] extra = 5'd0);
    logic [63:0] r;
    int g, nbt;
    req_tdata = mk(chan, sof, eof, flen, blen, extra);
    req_tvalid = 1;
    while (!req_tready) @(negedge clk);
    @(negedge clk);
    req_tvalid = 0;
    resp_tready = 1;
    while (!resp_tvalid) @(negedge clk);
    r = resp_tdata;
    @(negedge clk);
    resp_tready = 0;
    g = int'(r[63:48]);
    chk(r[47:0] === req_tdata[47:0], "R3", "echoed fields", 512'(r[47:0]), 512'(req_tdata[47:0]));
    if (exp_g >= 0) chk(g == exp_g, "R3", "grant", 512'(g), 512'(exp_g));
    if (exp_ferr >= 0) chk(proto_err === exp_ferr[0], "R10", "frame error pulse", 512'(proto_err), 512'(exp_ferr));
    if (g == 0) begin
      chk(req_tready === 1'b1 && data_tready === 1'b0, "R4", "zero grant returns to idle",
          512'({req_tready, data_tready}), 512'(2'b10));
    end
    nbt = (g + 63) / 64;
    for (int i = 0; i < nbt; i++) begin
      data_tdata = {16{32'(seed * 32'h9E3779B1 + i)}};
      data_tlast = (tlmode == 0) ? (i == nbt - 1) : (tlmode == 2) ? (i == 0) : 1'b0;
      data_tvalid = 1;
      while (!data_tready) @(negedge clk);
      @(negedge clk);
    end
    data_tvalid = 0; data_tlast = 0; seed++;
    if (nbt > 0) begin
      chk(data_tready === 1'b0, "R5", "data phase ended after beats", 512'(data_tready), 512'(0));
      if (tlmode != 0) chk(proto_err === 1'b1, "R8", "tlast mismatch pulse", 512'(proto_err), 512'(1));
    end
  endtask

  task automatic wait_empty();
    while (int'(free_bytes) != CAP) @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog R2 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(req_tready === 1 && resp_tvalid === 0 && data_tready === 0 && drain_valid === 0
        && proto_err === 0 && frame_open === '0 && int'(free_bytes) == CAP, "R1", "reset state",
        512'({req_tready, resp_tvalid, data_tready, drain_valid, proto_err, frame_open, free_bytes}),
        512'({1'b1, 4'b0, 4'b0, 11'(CAP)}));
    cmp_on = 1;
    rst = 0;
    @(negedge clk);
    // fill with drain stalled
    xact(0, 1, 1, 200, 200, 200, 0, 0, 5'h1A);
    chk(frame_open[0] === 1'b0, "R9", "single-transaction frame closed", 512'(frame_open), 512'(0));
    xact(1, 1, 0, 1000, 600, 600, 0, 0);
    chk(frame_open[1] === 1'b1, "R9", "frame opened", 512'(frame_open), 512'(2));
    xact(1, 0, 1, 0, 400, 128, 0, 0);
    chk(frame_open[1] === 1'b1, "R9", "partial eof keeps frame open", 512'(frame_open), 512'(2));
    chk(free_bytes === 11'd0, "R7", "buffer full", 512'(free_bytes), 512'(0));
    xact(1, 0, 1, 0, 272, 0, 0, 0);
    drain_mode = 1;
    wait_empty();
    xact(1, 0, 1, 0, 272, 272, 0, 0);
    chk(frame_open[1] === 1'b0, "R9", "frame closed at exact total", 512'(frame_open), 512'(0));
    // framing errors
    xact(2, 1, 1, 64, 64, 64, 1, 0);
    xact(5, 1, 0, 100, 50, 50, 0, 0);
    chk(frame_open[1] === 1'b1, "R9", "channel 5 maps to slot 1", 512'(frame_open), 512'(2));
    xact(1, 1, 1, 10, 10, 10, 0, 1);
    xact(3, 0, 0, 0, 64, 64, 0, 1);
    xact(0, 1, 0, 128, 64, 64, 0, 0);
    xact(0, 0, 1, 0, 100, 100, 0, 1);
    xact(2, 1, 1, 130, 130, 130, 2, 0);
    wait_empty();
    // boundaries with a jittery drain
    drain_mode = 2;
    xact(0, 1, 1, 1, 1, 1, 0, 0);
    xact(0, 1, 1, 63, 63, -1, 0, -1);
    xact(0, 1, 1, 64, 64, -1, 0, -1);
    xact(0, 1, 1, 65, 65, -1, 0, -1);
    xact(2, 1, 0, 99999, 32768, -1, 0, -1);
    for (int k = 0; k < 12; k++) xact(2, 0, 0, 0, 100 + k * 37, -1, 0, -1);
    drain_mode = 1;
    wait_empty();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule